// File: doc/BRIEF.md
# SD Host Command and Status Register Unit

This block is the byte-wide register front end of an SD/MMC host controller. Software writes the command opcode, a 32-bit argument, a response-type code, the block geometry and a control byte. The control byte carries the command kind in its upper nibble, a transfer direction bit, and two self-clearing action bits. One of these action bits launches the command, and the other flushes the response FIFO. Each action bit produces a single-cycle strobe toward the serial line engine. The decoded command kind and the block geometry drive the line engine directly.

Completion, timeout, CRC and card events from the line engine are latched into four status bytes. Writing a one to a status bit clears it. Each status byte has a mask byte. Together with a global enable bit in the block-length register, the masks fold the status into one level interrupt. The status bytes also show the card-detect and write-protect pins live. A soft-reset bit in the bus-mode byte clears the control, mask and status state in one cycle.

Top module: `sdh_cmd_unit`

## Requirements
- R1: A write to offset 0x00 with bit 0 set makes `cmd_start` high for exactly the following cycle. Bit 0 always reads back as 0.
- R2: A write to offset 0x00 with bit 3 set makes `rsp_fifo_clr` high for exactly the following cycle. Bit 3 always reads back as 0. Bit 2 of the same byte is stored and drives `cmd_write`.
- R3: Bits 7:4 of the control byte drive `cmd_kind`. The codes are 0 no data, 1 single write, 2 single read, 3 multi write, 4 multi read and 7 stop. `xfer_data` is high for codes 1 to 4. `xfer_read` is high for codes 2 and 4. `xfer_multi` is high for codes 3 and 4. `xfer_stop` is high for code 7.
- R4: The opcode (0x01) and the response type (0x02) drive their outputs and read back. The argument bytes at 0x04 to 0x07 form `cmd_arg`, with the lowest address as the least significant byte.
- R5: Status byte 1 (0x15) latches `ev_s1` bit by bit. Status bytes 2 (0x16) and 3 (0x17) latch `ev_s2` and `ev_s3`. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R6: When an event and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R7: Status byte 0 (0x14) shows the registered write-protect pin at bit 1 and the registered card-detect pin at bit 3. It latches multi-block done at bit 4, block done at bit 5 and device insertion at bit 7. Bit 6 latches a card-detect pin change, but only while block-length bit 13 is set.
- R8: `irq` is high exactly when block-length bit 15 is set and some status bit is set together with the same bit of its mask byte. The mask bytes are at 0x10 to 0x13.
- R9: The block length bytes (0x0C low, 0x0D high) hold length minus one in bits 10:0, which drive `blk_len_m1`. The block count bytes at 0x0E and 0x0F drive `blk_count`.
- R10: In the bus-mode byte (0x08), bit 1 drives `bus_w4`, bit 2 drives `bus_w8` and bit 4 drives `sd_pwr_off`. The byte reads back as written, except bit 7.
- R11: A write to 0x08 with bit 7 set clears the control byte, all mask bytes and all latched status bits at that edge. Events in that cycle are dropped. Bit 7 reads back as 0, and the opcode, argument and block registers are kept.
- R12: After reset all registers read 0, and `irq`, `cmd_start` and `rsp_fifo_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ev_s1 | input | 8 | Line-engine event pulses for status byte 1 |
| ev_s2 | input | 8 | Event pulses for status byte 2 |
| ev_s3 | input | 8 | Event pulses for status byte 3 |
| ev_blk_done | input | 1 | Block done pulse |
| ev_mblk_done | input | 1 | Multi-block done pulse |
| ev_dev_ins | input | 1 | Device inserted pulse |
| cd_pin | input | 1 | Card-detect pin level |
| wp_pin | input | 1 | Write-protect pin level |
| cmd_start | output | 1 | One-cycle command launch strobe |
| rsp_fifo_clr | output | 1 | One-cycle response FIFO flush strobe |
| cmd_opcode | output | 8 | Command opcode |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_type | output | 8 | Response type code |
| cmd_kind | output | 4 | Command kind code |
| cmd_write | output | 1 | Write-direction bit |
| xfer_data | output | 1 | Kind moves data |
| xfer_read | output | 1 | Kind is a read |
| xfer_multi | output | 1 | Kind is multi-block |
| xfer_stop | output | 1 | Kind is stop transmission |
| blk_len_m1 | output | 11 | Block length minus one |
| blk_count | output | 16 | Block count |
| bus_w4 | output | 1 | 4-bit bus selected |
| bus_w8 | output | 1 | 8-bit bus selected |
| sd_pwr_off | output | 1 | Card power off request |
| irq | output | 1 | Level interrupt |

## Verification
A line-engine event and the clearing write that software issues from its handler can land on the same status byte in the same cycle. The bench provokes this by driving an `ev_s1` bit and a write of that bit's mask to offset 0x15 in one cycle. It judges the result by reading the byte back: the bit that had an event must still be set, and a bit that was only cleared must be gone. A second overlap puts an event in the same cycle as the soft-reset write, and there the result must be that every bit is clear.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int SDH_AW    = 6;
  localparam int SDH_NSTAT = 4;

  // register offsets
  localparam int A_CTRL  = 0;
  localparam int A_OPC   = 1;
  localparam int A_RTYPE = 2;
  localparam int A_ARG0  = 4;
  localparam int A_BUS   = 8;
  localparam int A_BLKL0 = 12;
  localparam int A_BLKL1 = 13;
  localparam int A_BCNT0 = 14;
  localparam int A_BCNT1 = 15;
  localparam int A_MASK0 = 16;
  localparam int A_STAT0 = 20;
  localparam int ARG_BYTES = 4;

  // control byte bits
  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 2;
  localparam int CTL_FIFO  = 3;
  // bus mode bits
  localparam int BUS_W4   = 1;
  localparam int BUS_W8   = 2;
  localparam int BUS_OFF  = 4;
  localparam int BUS_SRST = 7;
  // block length register bits
  localparam int BL_LENW = 11;
  localparam int BL_GPI  = 13;
  localparam int BL_IE   = 15;

  // bits held in flops per status byte; byte 0 low nibble is live or unused
  localparam logic [SDH_NSTAT*8-1:0] SDH_LATCH = 32'hFFFF_FFF0;

  typedef enum logic [3:0] {
    K_NODATA = 4'd0,
    K_WR1    = 4'd1,
    K_RD1    = 4'd2,
    K_WRN    = 4'd3,
    K_RDN    = 4'd4,
    K_STOP   = 4'd7
  } cmd_kind_e;
endpackage

// File: rtl/sdh_cfg_regs.sv
module sdh_cfg_regs
  import sdh_pkg::*;
#(
  parameter int AW = SDH_AW,
  parameter int NS = SDH_NSTAT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           ctrl_q,
  output logic [7:0]           opc_q,
  output logic [7:0]           rtype_q,
  output logic [ARG_BYTES*8-1:0] arg_q,
  output logic [7:0]           bus_q,
  output logic [15:0]          blkl_q,
  output logic [15:0]          bcnt_q,
  output logic [NS-1:0][7:0]   mask_q,
  output logic                 start_q,
  output logic                 fifo_q,
  output logic                 srst
);
  logic [7:0]             ctrl_d, opc_d, rtype_d, bus_d;
  logic [ARG_BYTES*8-1:0] arg_d;
  logic [15:0]            blkl_d, bcnt_d;
  logic [NS-1:0][7:0]     mask_d;
  logic                   start_d, fifo_d, ctrl_hit;

  assign ctrl_hit = wr && (addr == AW'(A_CTRL));
  assign srst     = wr && (addr == AW'(A_BUS)) && wdata[BUS_SRST];
  assign start_d  = ctrl_hit && wdata[CTL_START];
  assign fifo_d   = ctrl_hit && wdata[CTL_FIFO];

  always_comb begin
    ctrl_d  = ctrl_q;
    opc_d   = opc_q;
    rtype_d = rtype_q;
    arg_d   = arg_q;
    bus_d   = bus_q;
    blkl_d  = blkl_q;
    bcnt_d  = bcnt_q;
    mask_d  = mask_q;
    if (ctrl_hit) begin
      ctrl_d = wdata;
      ctrl_d[CTL_START] = 1'b0;
      ctrl_d[CTL_FIFO]  = 1'b0;
    end
    if (wr && addr == AW'(A_OPC))   opc_d   = wdata;
    if (wr && addr == AW'(A_RTYPE)) rtype_d = wdata;
    if (wr && addr == AW'(A_BUS)) begin
      bus_d = wdata;
      bus_d[BUS_SRST] = 1'b0;
    end
    if (wr && addr == AW'(A_BLKL0)) blkl_d[7:0]  = wdata;
    if (wr && addr == AW'(A_BLKL1)) blkl_d[15:8] = wdata;
    if (wr && addr == AW'(A_BCNT0)) bcnt_d[7:0]  = wdata;
    if (wr && addr == AW'(A_BCNT1)) bcnt_d[15:8] = wdata;
    for (int k = 0; k < ARG_BYTES; k++)
      if (wr && addr == AW'(A_ARG0 + k)) arg_d[8*k +: 8] = wdata;
    for (int m = 0; m < NS; m++)
      if (wr && addr == AW'(A_MASK0 + m)) mask_d[m] = wdata;
    if (srst) begin
      ctrl_d = '0;
      mask_d = '0;
    end
  end

  // state registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      opc_q   <= '0;
      rtype_q <= '0;
      arg_q   <= '0;
      bus_q   <= '0;
      blkl_q  <= '0;
      bcnt_q  <= '0;
      mask_q  <= '0;
    end else if (wr) begin
      ctrl_q  <= ctrl_d;
      opc_q   <= opc_d;
      rtype_q <= rtype_d;
      arg_q   <= arg_d;
      bus_q   <= bus_d;
      blkl_q  <= blkl_d;
      bcnt_q  <= bcnt_d;
      mask_q  <= mask_d;
    end
  end

  // action strobes, one cycle each
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      fifo_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      fifo_q  <= fifo_d;
    end
  end
endmodule

// File: rtl/sdh_status_bank.sv
module sdh_status_bank
  import sdh_pkg::*;
#(
  parameter int AW = SDH_AW,
  parameter int NS = SDH_NSTAT,
  parameter int BASE = A_STAT0,
  parameter logic [NS*8-1:0] LATCH = SDH_LATCH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         wdata,
  input  logic               srst,
  input  logic [NS-1:0][7:0] evt,
  output logic [NS-1:0][7:0] sts
);
  for (genvar i = 0; i < NS; i++) begin : g_byte
    logic       hit, upd;
    logic [7:0] cur_q, nxt;

    assign hit = wr && (addr == AW'(BASE + i));
    assign upd = hit || srst || (|evt[i]);

    // clear first, then events on top: an event beats a same-cycle clear
    always_comb begin
      nxt = cur_q;
      if (hit) nxt = nxt & ~wdata;
      nxt = (nxt | evt[i]) & LATCH[8*i +: 8];
      if (srst) nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur_q <= '0;
      else if (upd) cur_q <= nxt;
    end

    assign sts[i] = cur_q;
  end
endmodule

// File: rtl/sdh_rd_mux.sv
module sdh_rd_mux
  import sdh_pkg::*;
#(
  parameter int AW = SDH_AW,
  parameter int NS = SDH_NSTAT
) (
  input  logic [AW-1:0]          addr,
  input  logic [7:0]             ctrl_q,
  input  logic [7:0]             opc_q,
  input  logic [7:0]             rtype_q,
  input  logic [ARG_BYTES*8-1:0] arg_q,
  input  logic [7:0]             bus_q,
  input  logic [15:0]            blkl_q,
  input  logic [15:0]            bcnt_q,
  input  logic [NS-1:0][7:0]     mask_q,
  input  logic [NS-1:0][7:0]     sts_view,
  output logic [7:0]             rdata
);
  always_comb begin
    rdata = '0;
    if (addr == AW'(A_CTRL))  rdata = ctrl_q;
    if (addr == AW'(A_OPC))   rdata = opc_q;
    if (addr == AW'(A_RTYPE)) rdata = rtype_q;
    if (addr == AW'(A_BUS))   rdata = bus_q;
    if (addr == AW'(A_BLKL0)) rdata = blkl_q[7:0];
    if (addr == AW'(A_BLKL1)) rdata = blkl_q[15:8];
    if (addr == AW'(A_BCNT0)) rdata = bcnt_q[7:0];
    if (addr == AW'(A_BCNT1)) rdata = bcnt_q[15:8];
    for (int k = 0; k < ARG_BYTES; k++)
      if (addr == AW'(A_ARG0 + k)) rdata = arg_q[8*k +: 8];
    for (int m = 0; m < NS; m++) begin
      if (addr == AW'(A_MASK0 + m)) rdata = mask_q[m];
      if (addr == AW'(A_STAT0 + m)) rdata = sts_view[m];
    end
  end
endmodule

// File: rtl/sdh_cmd_unit.sv
module sdh_cmd_unit
  import sdh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [7:0]  ev_s1,
  input  logic [7:0]  ev_s2,
  input  logic [7:0]  ev_s3,
  input  logic        ev_blk_done,
  input  logic        ev_mblk_done,
  input  logic        ev_dev_ins,
  input  logic        cd_pin,
  input  logic        wp_pin,
  output logic        cmd_start,
  output logic        rsp_fifo_clr,
  output logic [7:0]  cmd_opcode,
  output logic [31:0] cmd_arg,
  output logic [7:0]  cmd_rsp_type,
  output logic [3:0]  cmd_kind,
  output logic        cmd_write,
  output logic        xfer_data,
  output logic        xfer_read,
  output logic        xfer_multi,
  output logic        xfer_stop,
  output logic [10:0] blk_len_m1,
  output logic [15:0] blk_count,
  output logic        bus_w4,
  output logic        bus_w8,
  output logic        sd_pwr_off,
  output logic        irq
);
  localparam int NS = SDH_NSTAT;
  localparam int AW = SDH_AW;

  logic [7:0]         ctrl_q, bus_q;
  logic [15:0]        blkl_q;
  logic [NS-1:0][7:0] mask_q, evt, sts, sts_view;
  logic [NS-1:0]      hit;
  logic               srst_p, cd_q, wp_q, cd_chg, glob_ie;
  logic [7:0]         s1_view;
  cmd_kind_e          kind;

  sdh_cfg_regs #(.AW(AW), .NS(NS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .opc_q(cmd_opcode), .rtype_q(cmd_rsp_type), .arg_q(cmd_arg),
    .bus_q(bus_q), .blkl_q(blkl_q), .bcnt_q(blk_count), .mask_q(mask_q),
    .start_q(cmd_start), .fifo_q(rsp_fifo_clr), .srst(srst_p)
  );

  // pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q <= 1'b0;
      wp_q <= 1'b0;
    end else begin
      cd_q <= cd_pin;
      wp_q <= wp_pin;
    end
  end

  assign cd_chg = (cd_pin != cd_q) && blkl_q[BL_GPI];

  assign evt[0] = {ev_dev_ins, cd_chg, ev_blk_done, ev_mblk_done, 4'b0000};
  assign evt[1] = ev_s1;
  assign evt[2] = ev_s2;
  assign evt[3] = ev_s3;

  sdh_status_bank #(.AW(AW), .NS(NS), .BASE(A_STAT0), .LATCH(SDH_LATCH)) u_sts (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .srst(srst_p), .evt(evt), .sts(sts)
  );

  // status view: live pin levels merged into byte 0
  always_comb begin
    sts_view = sts;
    sts_view[0][1] = wp_q;
    sts_view[0][3] = cd_q;
  end
  assign s1_view = sts_view[1];

  for (genvar i = 0; i < NS; i++) begin : g_irq
    assign hit[i] = |(sts_view[i] & mask_q[i]);
  end
  assign glob_ie = blkl_q[BL_IE];
  assign irq     = glob_ie && (|hit);

  sdh_rd_mux #(.AW(AW), .NS(NS)) u_rd (
    .addr(reg_addr), .ctrl_q(ctrl_q), .opc_q(cmd_opcode), .rtype_q(cmd_rsp_type),
    .arg_q(cmd_arg), .bus_q(bus_q), .blkl_q(blkl_q), .bcnt_q(blk_count),
    .mask_q(mask_q), .sts_view(sts_view), .rdata(reg_rdata)
  );

  // command kind decode
  assign kind       = cmd_kind_e'(ctrl_q[7:4]);
  assign cmd_kind   = ctrl_q[7:4];
  assign cmd_write  = ctrl_q[CTL_DIR];
  assign xfer_data  = (kind == K_WR1) || (kind == K_RD1) || (kind == K_WRN) || (kind == K_RDN);
  assign xfer_read  = (kind == K_RD1) || (kind == K_RDN);
  assign xfer_multi = (kind == K_WRN) || (kind == K_RDN);
  assign xfer_stop  = (kind == K_STOP);

  assign blk_len_m1 = blkl_q[BL_LENW-1:0];
  assign bus_w4     = bus_q[BUS_W4];
  assign bus_w8     = bus_q[BUS_W8];
  assign sd_pwr_off = bus_q[BUS_OFF];
endmodule

// File: rtl/sdh_cmd_unit_chk.sv
module sdh_cmd_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [5:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] ev_s1,
  input logic       cmd_start,
  input logic       rsp_fifo_clr,
  input logic [3:0] cmd_kind,
  input logic       irq,
  input logic       glob_ie,
  input logic       srst_p,
  input logic [7:0] s1_view
);
  p_start_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(reg_wr && reg_addr == 6'd0 && reg_wdata[0]));

  p_fifo_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fifo_clr |-> $past(reg_wr && reg_addr == 6'd0 && reg_wdata[3]));

  p_kind_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_kind) |-> $past(reg_wr && (reg_addr == 6'd0 ||
                                  (reg_addr == 6'd8 && reg_wdata[7]))));

  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_s1 != 8'h00 && !srst_p) |=> ((s1_view & $past(ev_s1)) == $past(ev_s1)));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ie |-> !irq);

  p_srst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_p |=> (s1_view == 8'h00 && !irq));
endmodule

bind sdh_cmd_unit sdh_cmd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ev_s1(ev_s1), .cmd_start(cmd_start),
  .rsp_fifo_clr(rsp_fifo_clr), .cmd_kind(cmd_kind), .irq(irq),
  .glob_ie(glob_ie), .srst_p(srst_p), .s1_view(s1_view)
);

// File: tb/sdh_cmd_unit_bench.sv
`timescale 1ns/1ps
module sdh_cmd_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  ev_s1 = '0, ev_s2 = '0, ev_s3 = '0;
  logic        ev_blk_done = 1'b0, ev_mblk_done = 1'b0, ev_dev_ins = 1'b0;
  logic        cd_pin = 1'b0, wp_pin = 1'b0;
  logic        cmd_start, rsp_fifo_clr, cmd_write;
  logic [7:0]  cmd_opcode, cmd_rsp_type;
  logic [31:0] cmd_arg;
  logic [3:0]  cmd_kind;
  logic        xfer_data, xfer_read, xfer_multi, xfer_stop;
  logic [10:0] blk_len_m1;
  logic [15:0] blk_count;
  logic        bus_w4, bus_w8, sd_pwr_off, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdh_cmd_unit u_sdh_cmd_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_s1(ev_s1), .ev_s2(ev_s2),
    .ev_s3(ev_s3), .ev_blk_done(ev_blk_done), .ev_mblk_done(ev_mblk_done),
    .ev_dev_ins(ev_dev_ins), .cd_pin(cd_pin), .wp_pin(wp_pin),
    .cmd_start(cmd_start), .rsp_fifo_clr(rsp_fifo_clr), .cmd_opcode(cmd_opcode),
    .cmd_arg(cmd_arg), .cmd_rsp_type(cmd_rsp_type), .cmd_kind(cmd_kind),
    .cmd_write(cmd_write), .xfer_data(xfer_data), .xfer_read(xfer_read),
    .xfer_multi(xfer_multi), .xfer_stop(xfer_stop), .blk_len_m1(blk_len_m1),
    .blk_count(blk_count), .bus_w4(bus_w4), .bus_w8(bus_w8),
    .sd_pwr_off(sd_pwr_off), .irq(irq)
  );

  // {addr, write data, expected readback}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {6'd1,  8'h35, 8'h35},  // R4 opcode
    {6'd2,  8'h09, 8'h09},  // R4 response type
    {6'd4,  8'h78, 8'h78},  // R4 arg byte 0
    {6'd5,  8'h56, 8'h56},
    {6'd6,  8'h34, 8'h34},
    {6'd7,  8'h12, 8'h12},
    {6'd12, 8'hFF, 8'hFF},  // R9 length low
    {6'd13, 8'h21, 8'h21},  // R9 length high, card-detect select
    {6'd14, 8'h08, 8'h08},  // R9 count
    {6'd15, 8'h00, 8'h00},
    {6'd17, 8'h16, 8'h16},  // R8 mask byte 1
    {6'd8,  8'h12, 8'h12},  // R10 bus mode
    {6'd0,  8'h45, 8'h44},  // R1 start bit self-clears
    {6'd16, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic pulse_s1(input logic [7:0] v);
    @(negedge clk);
    ev_s1 = v;
    @(posedge clk); #1;
    ev_s1 = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    rd_chk("R12 ctrl", 6'd0, 8'h00);
    rd_chk("R12 mask1", 6'd17, 8'h00);
    rd_chk("R12 stat1", 6'd21, 8'h00);
    check("R12 outputs", {irq, cmd_start, rsp_fifo_clr}, 3'b000);

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      wr_reg(VEC[i][21:16], VEC[i][15:8]);
      rd_chk("R4/R9/R10 table", VEC[i][21:16], VEC[i][7:0]);
    end
    check("R4 arg", cmd_arg, 32'h1234_5678);
    check("R4 opc/rtype", {cmd_opcode, cmd_rsp_type}, {8'h35, 8'h09});
    check("R9 len/count", {blk_len_m1, blk_count}, {11'h1FF, 16'd8});
    check("R10 bus", {bus_w8, bus_w4, sd_pwr_off}, 3'b011);
    check("R3 kind 4", {cmd_kind, xfer_data, xfer_read, xfer_multi, xfer_stop}, {4'd4, 4'b1110});
    check("R2 dir bit", cmd_write, 1'b1);

    // R1 start pulse width
    wr_reg(6'd0, 8'h11);
    check("R1 start high", cmd_start, 1'b1);
    check("R3 kind 1", {cmd_kind, xfer_data, xfer_read, xfer_multi, cmd_write}, {4'd1, 4'b1000});
    @(posedge clk); #1;
    check("R1 start low", cmd_start, 1'b0);
    rd_chk("R1 readback", 6'd0, 8'h10);

    // R2 fifo flush and stop kind
    wr_reg(6'd0, 8'h78);
    check("R2 fifo high", {rsp_fifo_clr, cmd_start}, 2'b10);
    check("R3 stop", {cmd_kind, xfer_stop, xfer_data}, {4'd7, 2'b10});
    @(posedge clk); #1;
    check("R2 fifo low", rsp_fifo_clr, 1'b0);
    rd_chk("R2 readback", 6'd0, 8'h70);
    wr_reg(6'd0, 8'h30);
    check("R3 kind 3", {xfer_data, xfer_read, xfer_multi}, 3'b101);
    wr_reg(6'd0, 8'h20);
    check("R3 kind 2", {xfer_data, xfer_read, xfer_multi}, 3'b110);

    // R5 latch and clear, interrupt globally off
    pulse_s1(8'h02);
    rd_chk("R5 set", 6'd21, 8'h02);
    check("R8 global off", irq, 1'b0);
    wr_reg(6'd21, 8'h00);
    rd_chk("R5 zero write keeps", 6'd21, 8'h02);
    wr_reg(6'd21, 8'h02);
    rd_chk("R5 cleared", 6'd21, 8'h00);
    @(negedge clk); ev_s3 = 8'h81; @(posedge clk); #1 ev_s3 = '0;
    rd_chk("R5 byte3", 6'd23, 8'h81);

    // R8 interrupt gating
    wr_reg(6'd13, 8'hA1);
    check("R8 masked-off stat3", irq, 1'b0);
    pulse_s1(8'h08);
    check("R8 unmasked bit", irq, 1'b0);
    pulse_s1(8'h02);
    check("R8 masked bit", irq, 1'b1);
    wr_reg(6'd21, 8'h0A);
    check("R8 after clear", irq, 1'b0);

    // R6 event against clear in the same cycle
    pulse_s1(8'h10);
    @(negedge clk);
    ev_s1 = 8'h04; reg_wr = 1'b1; reg_addr = 6'd21; reg_wdata = 8'h14;
    @(posedge clk); #1;
    ev_s1 = '0; reg_wr = 1'b0;
    rd_chk("R6 event wins", 6'd21, 8'h04);
    wr_reg(6'd21, 8'h04);

    // R7 status byte 0
    @(negedge clk); wp_pin = 1'b1; cd_pin = 1'b1;
    @(posedge clk); #1;
    rd_chk("R7 live and edge", 6'd20, 8'h4A);
    wr_reg(6'd20, 8'hFF);
    rd_chk("R7 clear keeps live", 6'd20, 8'h0A);
    @(negedge clk); ev_blk_done = 1'b1; ev_dev_ins = 1'b1; ev_mblk_done = 1'b1;
    @(posedge clk); #1;
    ev_blk_done = 1'b0; ev_dev_ins = 1'b0; ev_mblk_done = 1'b0;
    rd_chk("R7 latched", 6'd20, 8'hBA);
    wr_reg(6'd16, 8'h20);
    check("R8 mask0 block done", irq, 1'b1);
    wr_reg(6'd20, 8'hB0);
    wr_reg(6'd13, 8'h81);
    @(negedge clk); cd_pin = 1'b0;
    @(posedge clk); #1;
    rd_chk("R7 edge ignored unselected", 6'd20, 8'h02);

    // R11 soft reset with a coincident event
    wr_reg(6'd0, 8'h44);
    pulse_s1(8'h06);
    @(negedge clk);
    ev_s1 = 8'h80; reg_wr = 1'b1; reg_addr = 6'd8; reg_wdata = 8'h82;
    @(posedge clk); #1;
    ev_s1 = '0; reg_wr = 1'b0;
    rd_chk("R11 bus", 6'd8, 8'h02);
    rd_chk("R11 ctrl", 6'd0, 8'h00);
    rd_chk("R11 mask1", 6'd17, 8'h00);
    rd_chk("R11 stat1", 6'd21, 8'h00);
    rd_chk("R11 opcode kept", 6'd1, 8'h35);
    check("R11 irq/width", {irq, bus_w4}, 2'b01);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule